// File: doc/BRIEF.md
# Edge Capture Down-Counter Timer

This block measures the time between chosen transitions on an asynchronous input. A programmable prescaler divides the system clock. Each time the prescaler runs out, a 16-bit counter steps down by one, starting from all ones. When the chosen transition arrives, the counter value is copied into a capture register and the counter starts again from all ones. The prescaler keeps its phase through the capture.

Software works through a byte-wide register port with four addresses: control, prescaler reload, capture low byte and capture high byte. A capture sets a capture flag. A counter wrap from zero to all ones sets a wrap flag. Both flags stay set until software writes zero to them. One enable bit gates either flag onto a single interrupt request line. Clearing the run bit freezes the timer and ignores the input. Setting it again starts from a clean state.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the control register reads 8'h00 and irq is low.
- R2: Register addresses are: 0 control, 1 prescaler reload (read/write), 2 capture bits 7:0 and 3 capture bits 15:8. Both capture addresses are read-only, and writes to them are ignored. Control bits are: bit0 run, bit1 interrupt enable, bit2 wrap flag, bit3 capture flag, bit4 edge select (0 rising, 1 falling). Bits 7:5 read 0 and ignore writes.
- R3: A write that changes run from 0 to 1 loads the counter with 16'hFFFF and the prescaler with the reload value P. The counter then drops by one on every (P+1)-th clock edge after the start edge. An input change driven before clock edge k is recognised through a two-stage synchroniser and captured on edge k+2. The value stored is the counter value held just before that edge.
- R4: A capture reloads the counter with 16'hFFFF and leaves the prescaler phase untouched.
- R5: Only the selected transition captures. The opposite transition leaves the capture flag and the capture value as they were.
- R6: The counter stepping from 16'h0000 sets the wrap flag, provided no capture happens on that edge. With P=0 this is the 65536th edge after start.
- R7: irq is high exactly when the interrupt enable is set and at least one flag is set.
- R8: A flag is cleared by writing 0 to its bit. Writing 1 to a flag bit leaves it unchanged and never sets it.
- R9: When a flag-clearing write and the hardware event that sets the same flag land on the same edge, the flag ends up set.
- R10: While run is 0, input transitions produce no capture: the flag stays clear and the capture value is held.
- R11: Setting run again after a stop starts counting afresh from 16'hFFFF with the current reload value.
- R12: Writing run=1 while already running does not restart the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cap_in | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data, combinational on addr |
| irq | output | 1 | Interrupt request |

## Verification
A capture can set the capture flag on the same edge that a software write clears it. The bench provokes this by changing the input and issuing the clearing control write two cycles later, so the write edge is exactly the capture edge. It judges the result by reading back the control register and checking that the flag is set and that irq is asserted with the enable on. A later write then shows that the same clear does work when no capture collides with it.

// File: rtl/ect_pkg.sv
package ect_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_PSC  = 2'd1;
    localparam logic [1:0] REG_CAPL = 2'd2;
    localparam logic [1:0] REG_CAPH = 2'd3;

    localparam int BIT_RUN  = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_UF   = 2;
    localparam int BIT_CAP  = 3;
    localparam int BIT_EDGE = 4;

    typedef struct packed {
        logic edge_fall;
        logic cap_pend;
        logic uf_pend;
        logic ie;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/ect_edge_detect.sv
module ect_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic enable,
    input  logic fall_sel,
    output logic cap_evt
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [MSB:0] sync;
        logic         prev;
    } st_t;

    st_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[MSB-1:0], din};
        s_d.prev = s_q.sync[MSB];
        rise     = s_q.sync[MSB] & ~s_q.prev;
        fall     = ~s_q.sync[MSB] & s_q.prev;
        cap_evt  = enable & (fall_sel ? fall : rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ect_prescaler.sv
module ect_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = run && (cnt_q == '0);
        if (start)      cnt_d = reload;
        else if (tick)  cnt_d = reload;
        else if (run)   cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ect_down_counter.sv
module ect_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic         tick,
    input  logic         capture,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = run && tick && !capture && (cnt_q == '0);
        if (start)                cnt_d = '1;
        else if (run && capture)  cnt_d = '1;
        else if (run && tick)     cnt_d = cnt_q - W'(1);
        cnt = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import ect_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] psc;
        logic [CNT_W-1:0]  cap;
    } regs_t;

    regs_t r_d, r_q;

    logic             wr_ctrl, start, tick, cap_evt, wrap;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, ie_q, uf_pend_q, cap_pend_q;
    logic [CNT_W-1:0] cap_q;

    assign run_q      = r_q.ctrl.run;
    assign ie_q       = r_q.ctrl.ie;
    assign uf_pend_q  = r_q.ctrl.uf_pend;
    assign cap_pend_q = r_q.ctrl.cap_pend;
    assign cap_q      = r_q.cap;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign start   = wr_ctrl && wr_data[BIT_RUN] && !run_q;

    ect_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cap_in),
        .enable   (run_q),
        .fall_sel (r_q.ctrl.edge_fall),
        .cap_evt  (cap_evt)
    );

    ect_prescaler #(.W(DATA_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run_q),
        .reload (r_q.psc),
        .tick   (tick)
    );

    ect_down_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (run_q),
        .tick    (tick),
        .capture (cap_evt),
        .cnt     (cnt_q),
        .wrap    (wrap)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl.run       = wr_data[BIT_RUN];
            r_d.ctrl.ie        = wr_data[BIT_IE];
            r_d.ctrl.edge_fall = wr_data[BIT_EDGE];
            r_d.ctrl.uf_pend   = r_q.ctrl.uf_pend & wr_data[BIT_UF];
            r_d.ctrl.cap_pend  = r_q.ctrl.cap_pend & wr_data[BIT_CAP];
        end
        if (wr_en && (addr == REG_PSC)) r_d.psc = wr_data;
        // hardware events applied last so they win over a clearing write
        if (cap_evt) begin
            r_d.cap           = cnt_q;
            r_d.ctrl.cap_pend = 1'b1;
        end
        if (wrap) r_d.ctrl.uf_pend = 1'b1;
    end

    // only the control fields take reset; reload and capture values persist
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.ctrl <= '0;
        else        r_q      <= r_d;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            REG_CTRL: begin
                rd_data[BIT_RUN]  = run_q;
                rd_data[BIT_IE]   = ie_q;
                rd_data[BIT_UF]   = uf_pend_q;
                rd_data[BIT_CAP]  = cap_pend_q;
                rd_data[BIT_EDGE] = r_q.ctrl.edge_fall;
            end
            REG_PSC:  rd_data = r_q.psc;
            REG_CAPL: rd_data = cap_q[DATA_W-1:0];
            default:  rd_data = cap_q[CNT_W-1:DATA_W];
        endcase
        irq = ie_q & (uf_pend_q | cap_pend_q);
    end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                irq,
    input logic                run_q,
    input logic                ie_q,
    input logic                uf_pend_q,
    input logic                cap_pend_q,
    input logic [2*DATA_W-1:0] cnt_q,
    input logic [2*DATA_W-1:0] cap_q,
    input logic                tick,
    input logic                cap_evt
);
    localparam int CNT_W = 2 * DATA_W;

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);

    // R9
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_pend_q);

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pend_q && !(wr_en && addr == 2'd0 && !wr_data[3]) |=> cap_pend_q);

    // R4
    restart_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cnt_q == {CNT_W{1'b1}});

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && tick && !cap_evt |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && tick && !cap_evt && cnt_q == '0 |=> uf_pend_q);

    // R10
    frozen_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !$isunknown(cap_q) |=> $stable(cap_q));
endmodule

bind edge_capture_timer ect_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .irq        (irq),
    .run_q      (run_q),
    .ie_q       (ie_q),
    .uf_pend_q  (uf_pend_q),
    .cap_pend_q (cap_pend_q),
    .cnt_q      (cnt_q),
    .cap_q      (cap_q),
    .tick       (tick),
    .cap_evt    (cap_evt)
);

// File: tb/edge_capture_timer_test.sv
`timescale 1ns/1ps
module edge_capture_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int s = 0;
    int n1 = 0;

    edge_capture_timer uut (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic chk_cap(input string req, input logic [15:0] exp);
        chk_reg(req, 2'd2, exp[7:0]);
        chk_reg(req, 2'd3, exp[15:8]);
    endtask

    task automatic start_timer(input logic [7:0] ctrl);
        wr(2'd0, ctrl);
        s = cyc;
    endtask

    task automatic t_reset;
        chk_reg("R1 ctrl", 2'd0, 8'h00);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_regs;
        wr(2'd1, 8'hA5);
        chk_reg("R2 psc readback", 2'd1, 8'hA5);
        wr(2'd0, 8'hE0);
        chk_reg("R2 upper ctrl bits", 2'd0, 8'h00);
        wr(2'd1, 8'h03);
    endtask

    task automatic t_capture;
        start_timer(8'h01);
        idle(21);
        n1 = cyc - s;
        cap_in = 1'b1;
        idle(5);
        chk_cap("R3 capture value", 16'hFFFF - 16'((n1 + 2) / 4));
        chk_reg("R3 capture flag", 2'd0, 8'h09);
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        wr(2'd2, 8'h55);
        wr(2'd3, 8'h00);
        chk_cap("R2 capture read-only", 16'hFFFF - 16'((n1 + 2) / 4));
    endtask

    task automatic t_second;
        int m;
        wr(2'd0, 8'h01);
        idle(1);
        cap_in = 1'b0;
        idle(5);
        chk_reg("R5 falling ignored", 2'd0, 8'h01);
        idle(3);
        m = cyc - s;
        cap_in = 1'b1;
        idle(5);
        chk_cap("R4 R12 second capture",
                16'hFFFF - 16'(((m + 2) / 4) - ((n1 + 3) / 4)));
    endtask

    task automatic t_falling;
        int n;
        wr(2'd0, 8'h00);
        cap_in = 1'b0;
        idle(4);
        start_timer(8'h11);
        idle(2);
        cap_in = 1'b1;
        idle(5);
        chk_reg("R5 rising ignored", 2'd0, 8'h11);
        idle(3);
        n = cyc - s;
        cap_in = 1'b0;
        idle(5);
        chk_cap("R5 falling capture", 16'hFFFF - 16'((n + 2) / 4));
        chk_reg("R5 falling flag", 2'd0, 8'h19);
    endtask

    task automatic t_irq_flags;
        wr(2'd0, 8'h1B);
        chk_reg("R8 write one keeps", 2'd0, 8'h1B);
        chk("R7 irq on", {31'h0, irq}, 32'h1);
        wr(2'd0, 8'h13);
        chk_reg("R8 clear", 2'd0, 8'h13);
        chk("R7 irq off", {31'h0, irq}, 32'h0);
        wr(2'd0, 8'h17);
        chk_reg("R8 write one no set", 2'd0, 8'h13);
    endtask

    task automatic t_collide;
        cap_in = 1'b1;
        idle(4);
        cap_in = 1'b0;
        idle(2);
        wr(2'd0, 8'h13);
        chk_reg("R9 set wins", 2'd0, 8'h1B);
        chk("R9 irq", {31'h0, irq}, 32'h1);
        wr(2'd0, 8'h13);
        chk_reg("R9 later clear", 2'd0, 8'h13);
    endtask

    task automatic t_stopped;
        logic [7:0] lo, hi;
        wr(2'd0, 8'h00);
        rd(2'd2, lo);
        rd(2'd3, hi);
        cap_in = 1'b1;
        idle(4);
        cap_in = 1'b0;
        idle(4);
        chk_reg("R10 no flag", 2'd0, 8'h00);
        chk_cap("R10 capture held", {hi, lo});
    endtask

    task automatic t_restart;
        wr(2'd1, 8'h01);
        start_timer(8'h01);
        idle(12);
        cap_in = 1'b1;
        idle(5);
        chk_cap("R11 restart capture", 16'hFFF8);
    endtask

    task automatic t_wrap;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        start_timer(8'h03);
        idle(65535);
        chk_reg("R6 before wrap", 2'd0, 8'h03);
        chk("R6 irq before", {31'h0, irq}, 32'h0);
        idle(1);
        chk_reg("R6 after wrap", 2'd0, 8'h07);
        chk("R6 irq after", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        #3_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_capture();
        t_second();
        t_falling();
        t_irq_flags();
        t_collide();
        t_stopped();
        t_restart();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule